// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block is the target side of a narrow management register port. The host sees 5-bit register numbers and 16-bit data only. A few of those registers form a window into a much larger paged register space inside the device, where one register can be up to 64 bits wide. The serial framing of the management bus is handled elsewhere. This block sees only parallel read and write strobes with an address and data.

The host selects a page and sets a page-enable flag in the page register. For a write, it fills up to four 16-bit data words and then writes the command register with a register offset and an operation bit. The bridge then runs one transaction on an internal request/acknowledge bus, using the page, offset, direction and the 64-bit value formed by the data words. The operation bits stay set while the transaction is in flight, and the host polls the command register until they read as zero. After a read completes, the returned 64-bit value sits in the data words. The page register keeps its value, so a run of accesses to one page sets it only once.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset the page register, the command register and all four data words read as zero, and `ib_req` is low.
- R2: Window register 0x10 stores a page number from write-data bits [15:8] and a page-enable flag from bit 0. It reads back as {page, 7'b0, enable}, with all other bits zero. It keeps its value across any number of commands.
- R3: Window registers 0x18..0x1B are data words. Word 0x18+k holds bits [16k+15:16k] of the 64-bit internal value, and each word reads back what was last written to it or captured into it.
- R4: A write to register 0x11 while idle, with the page enabled and bit 0 (write) or bit 1 (read) set, starts exactly one internal transaction. `ib_req` rises in the cycle after the strobe and stays high until the cycle in which `ib_ack` is seen. Throughout, `ib_page`, `ib_offset` (from command bits [15:8]), `ib_we` and `ib_wdata` (the four data words) stay stable.
- R5: Register 0x11 reads back as {offset, 6'b0, read_busy, write_busy}. The active operation bit reads as one while the transaction is pending and clears once `ib_ack` is accepted, and `ib_req` drops in the cycle after that.
- R6: When a read transaction is acknowledged, the four data words take `ib_rdata`. A write transaction leaves the data words unchanged.
- R7: A command with both operation bits set runs a read, and only bit 1 reads back as set while it is busy.
- R8: While a transaction is busy, writes to register 0x11 are ignored entirely (no offset change, no extra transaction), and so are writes to the data words.
- R9: If the page-enable flag is clear, a command write stores its offset but starts no transaction, and both operation bits read as zero.
- R10: Reads of window registers other than 0x10, 0x11 and 0x18..0x1B return zero, and writes to them change no register.
- R11: A read strobe in one cycle puts the addressed value on `mgmt_rdata` from the next cycle on. `mgmt_rdata` holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_wr | input | 1 | Management register write strobe |
| mgmt_rd | input | 1 | Management register read strobe |
| mgmt_addr | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Registered management read data |
| ib_req | output | 1 | Internal bus request, held until acknowledge |
| ib_we | output | 1 | Internal bus direction, 1 = write |
| ib_page | output | 8 | Internal bus page number |
| ib_offset | output | 8 | Internal bus register offset within the page |
| ib_wdata | output | 64 | Internal bus write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 64 | Internal bus read data, valid with acknowledge |

## Verification
The assertions assume that the internal responder raises `ib_ack` only while `ib_req` is high, and drops it again in the cycle after the handshake. They also assume that strobes last a single cycle. The stimulus keeps to these rules. Its responder raises acknowledge after a programmable countdown that starts when it sees a request, and lowers it on the next cycle. The management driver pulses each strobe for exactly one clock and never issues a read and a write together.

// File: rtl/pib_pkg.sv
package pib_pkg;
  localparam logic [4:0] WIN_PAGE  = 5'h10;
  localparam logic [4:0] WIN_CMD   = 5'h11;
  localparam logic [4:0] WIN_DATA0 = 5'h18;

  localparam int OP_WR_BIT   = 0;
  localparam int OP_RD_BIT   = 1;
  localparam int PAGE_EN_BIT = 0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } pib_state_e;
endpackage

// File: rtl/pib_page_reg.sv
module pib_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_enable,
  output logic [PAGE_W-1:0] page_q,
  output logic              enable_q
);
  logic [PAGE_W-1:0] page_d;
  logic              enable_d;

  always_comb begin
    page_d   = page_q;
    enable_d = enable_q;
    if (wr_en) begin
      page_d   = wr_page;
      enable_d = wr_enable;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      enable_q <= 1'b0;
    end else if (wr_en) begin
      page_q   <= page_d;
      enable_q <= enable_d;
    end
  end

  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(page_q) && $stable(enable_q));
endmodule

// File: rtl/pib_data_bank.sv
module pib_data_bank #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int FLAT_W   = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              lock,
  input  logic              cap_en,
  input  logic [FLAT_W-1:0] cap_data,
  output logic [FLAT_W-1:0] words_flat
);
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic              word_en;

    always_comb begin
      word_en = 1'b0;
      word_d  = word_q;
      if (cap_en) begin
        word_en = 1'b1;
        word_d  = cap_data[k*WORD_W +: WORD_W];
      end else if (wr_en && !lock && (wr_idx == IDX_W'(k))) begin
        word_en = 1'b1;
        word_d  = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign words_flat[k*WORD_W +: WORD_W] = word_q;
  end

  p_locked_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !cap_en) |=> $stable(words_flat));
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (words_flat == $past(cap_data)));
endmodule

// File: rtl/pib_cmd_fsm.sv
module pib_cmd_fsm #(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [OFFS_W-1:0] cmd_offset,
  input  logic              cmd_rd_bit,
  input  logic              cmd_wr_bit,
  input  logic              page_en,
  input  logic [PAGE_W-1:0] page_num,
  input  logic              ib_ack,
  output logic              busy,
  output logic              op_rd,
  output logic              op_wr,
  output logic [OFFS_W-1:0] offset_q,
  output logic              cap_en,
  output logic              ib_req,
  output logic              ib_we,
  output logic [PAGE_W-1:0] ib_page
);
  import pib_pkg::*;

  pib_state_e        state_q, state_d;
  logic [OFFS_W-1:0] offset_d;
  logic [PAGE_W-1:0] pg_q, pg_d;
  logic              rd_q, rd_d, wr_q, wr_d;
  logic              start;
  logic              reg_en;

  assign start = cmd_wr && (state_q == ST_IDLE) && page_en && (cmd_rd_bit || cmd_wr_bit);

  always_comb begin
    state_d  = state_q;
    offset_d = offset_q;
    pg_d     = pg_q;
    rd_d     = rd_q;
    wr_d     = wr_q;
    cap_en   = 1'b0;
    reg_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          reg_en   = 1'b1;
          offset_d = cmd_offset;
          rd_d     = 1'b0;
          wr_d     = 1'b0;
          if (start) begin
            state_d = ST_BUSY;
            pg_d    = page_num;
            rd_d    = cmd_rd_bit;
            wr_d    = !cmd_rd_bit;
          end
        end
      end
      ST_BUSY: begin
        if (ib_ack) begin
          reg_en  = 1'b1;
          state_d = ST_IDLE;
          cap_en  = rd_q;
          rd_d    = 1'b0;
          wr_d    = 1'b0;
        end
      end
      default: begin
        reg_en  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      offset_q <= '0;
      pg_q     <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else if (reg_en) begin
      state_q  <= state_d;
      offset_q <= offset_d;
      pg_q     <= pg_d;
      rd_q     <= rd_d;
      wr_q     <= wr_d;
    end
  end

  assign busy    = (state_q == ST_BUSY);
  assign ib_req  = busy;
  assign ib_we   = wr_q;
  assign ib_page = pg_q;
  assign op_rd   = rd_q;
  assign op_wr   = wr_q;

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ib_req);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack) |=> ib_req && $stable(ib_page) && $stable(ib_we) && $stable(offset_q));
  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && ib_ack) |=> !ib_req && !op_rd && !op_wr);
  p_ops_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_rd, op_wr}) && (ib_req == (op_rd || op_wr)));
  p_both_is_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cmd_rd_bit) |=> op_rd && !ib_we);
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge #(
  parameter int ADDR_W    = 5,
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int PAGE_W    = 8,
  parameter int OFFS_W    = 8,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int FLAT_W   = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_wr,
  input  logic              mgmt_rd,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [WORD_W-1:0] mgmt_wdata,
  output logic [WORD_W-1:0] mgmt_rdata,
  output logic              ib_req,
  output logic              ib_we,
  output logic [PAGE_W-1:0] ib_page,
  output logic [OFFS_W-1:0] ib_offset,
  output logic [FLAT_W-1:0] ib_wdata,
  input  logic              ib_ack,
  input  logic [FLAT_W-1:0] ib_rdata
);
  import pib_pkg::*;

  localparam int PAGE_PAD = WORD_W - PAGE_W - 1;
  localparam int CMD_PAD  = WORD_W - OFFS_W - 2;

  logic              sel_page, sel_cmd, sel_data;
  logic [ADDR_W-1:0] data_off;
  logic [IDX_W-1:0]  data_idx;
  logic [PAGE_W-1:0] page_q;
  logic              page_en;
  logic              busy, op_rd, op_wr, cap_en;
  logic [OFFS_W-1:0] offset_q;
  logic [FLAT_W-1:0] words_flat;
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] rdata_q;

  assign data_off = mgmt_addr - ADDR_W'(WIN_DATA0);
  assign data_idx = data_off[IDX_W-1:0];
  assign sel_page = (mgmt_addr == ADDR_W'(WIN_PAGE));
  assign sel_cmd  = (mgmt_addr == ADDR_W'(WIN_CMD));
  assign sel_data = (mgmt_addr >= ADDR_W'(WIN_DATA0)) && (data_off < ADDR_W'(NUM_WORDS));

  pib_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mgmt_wr && sel_page),
    .wr_page   (mgmt_wdata[WORD_W-1 -: PAGE_W]),
    .wr_enable (mgmt_wdata[PAGE_EN_BIT]),
    .page_q    (page_q),
    .enable_q  (page_en)
  );

  pib_cmd_fsm #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (mgmt_wr && sel_cmd),
    .cmd_offset (mgmt_wdata[WORD_W-1 -: OFFS_W]),
    .cmd_rd_bit (mgmt_wdata[OP_RD_BIT]),
    .cmd_wr_bit (mgmt_wdata[OP_WR_BIT]),
    .page_en    (page_en),
    .page_num   (page_q),
    .ib_ack     (ib_ack),
    .busy       (busy),
    .op_rd      (op_rd),
    .op_wr      (op_wr),
    .offset_q   (offset_q),
    .cap_en     (cap_en),
    .ib_req     (ib_req),
    .ib_we      (ib_we),
    .ib_page    (ib_page)
  );

  pib_data_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (mgmt_wr && sel_data),
    .wr_idx     (data_idx),
    .wr_data    (mgmt_wdata),
    .lock       (busy),
    .cap_en     (cap_en),
    .cap_data   (ib_rdata),
    .words_flat (words_flat)
  );

  assign ib_offset = offset_q;
  assign ib_wdata  = words_flat;

  always_comb begin
    rd_mux = '0;
    if (sel_page) begin
      rd_mux = {page_q, {PAGE_PAD{1'b0}}, page_en};
    end else if (sel_cmd) begin
      rd_mux = {offset_q, {CMD_PAD{1'b0}}, op_rd, op_wr};
    end else if (sel_data) begin
      rd_mux = words_flat[data_idx*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (mgmt_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign mgmt_rdata = rdata_q;

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && sel_cmd && !page_en && !busy) |=> !ib_req && !op_rd && !op_wr);
  p_busy_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ib_ack) |=> $stable(ib_offset) && $stable(ib_wdata));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_rd |=> $stable(mgmt_rdata));
  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack) |=> $stable(ib_wdata));
endmodule

// File: tb/test_paged_reg_bridge.sv
module test_paged_reg_bridge;
  logic        clk;
  logic        rst_n;
  logic        mgmt_wr, mgmt_rd;
  logic [4:0]  mgmt_addr;
  logic [15:0] mgmt_wdata;
  logic [15:0] mgmt_rdata;
  logic        ib_req, ib_we, ib_ack;
  logic [7:0]  ib_page, ib_offset;
  logic [63:0] ib_wdata, ib_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [63:0] mem [bit [15:0]];
  int          resp_lat = 0;
  int          lat_cnt  = 0;
  int          txn_cnt  = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        sb_en = 0;
  logic        rd_d;

  paged_reg_bridge i_paged_reg_bridge (
    .clk(clk), .rst_n(rst_n),
    .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
    .ib_req(ib_req), .ib_we(ib_we), .ib_page(ib_page), .ib_offset(ib_offset),
    .ib_wdata(ib_wdata), .ib_ack(ib_ack), .ib_rdata(ib_rdata)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // responder: ack after resp_lat counted cycles, dropped the cycle after
  always @(negedge clk) begin
    if (!rst_n) begin
      ib_ack   <= 1'b0;
      ib_rdata <= '0;
      lat_cnt  <= resp_lat;
    end else if (ib_ack) begin
      ib_ack  <= 1'b0;
      lat_cnt <= resp_lat;
    end else if (ib_req) begin
      if (lat_cnt == 0) begin
        ib_ack <= 1'b1;
        txn_cnt <= txn_cnt + 1;
        if (ib_we) mem[{ib_page, ib_offset}] = ib_wdata;
        else ib_rdata <= mem.exists({ib_page, ib_offset}) ? mem[{ib_page, ib_offset}] : 64'h0;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end else begin
      lat_cnt <= resp_lat;
    end
  end

  // scoreboard monitor
  always @(posedge clk) rd_d <= mgmt_rd && sb_en;
  always @(negedge clk) begin
    if (rst_n && rd_d) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard empty actual=%h expected=none", mgmt_rdata);
      end else begin
        chk(tag_q.pop_front(), {48'h0, mgmt_rdata}, {48'h0, exp_q.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic mwrite(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    mgmt_wr = 1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_wr = 0;
  endtask

  task automatic mread_exp(logic [4:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    sb_en = 1; mgmt_rd = 1; mgmt_addr = a;
    @(negedge clk);
    mgmt_rd = 0; sb_en = 0;
  endtask

  task automatic mread_raw(logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    mgmt_rd = 1; mgmt_addr = a;
    @(negedge clk);
    mgmt_rd = 0;
    v = mgmt_rdata;
  endtask

  task automatic poll_done(string tag);
    logic [15:0] v;
    for (int i = 0; i < 200; i++) begin
      mread_raw(5'h11, v);
      if (v[1:0] == 2'b00) return;
    end
    chk(tag, {62'h0, v[1:0]}, 64'h0);
  endtask

  initial begin
    int base;
    logic [15:0] v;
    rst_n = 0; mgmt_wr = 0; mgmt_rd = 0; mgmt_addr = 0; mgmt_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 ib_req", {63'h0, ib_req}, 64'h0);
    mread_exp(5'h10, 16'h0000, "R1 page");
    mread_exp(5'h11, 16'h0000, "R1 cmd");
    for (int k = 0; k < 4; k++) mread_exp(5'(8'h18 + k), 16'h0000, "R1 data");
    // R10 undefined read
    mread_exp(5'h12, 16'h0000, "R10 undef read");
    mread_exp(5'h1F, 16'h0000, "R10 undef read");

    // R2 page layout
    mwrite(5'h10, 16'hFFFF);
    mread_exp(5'h10, 16'hFF01, "R2 page fields");
    mwrite(5'h10, 16'h3401);
    mread_exp(5'h10, 16'h3401, "R2 page readback");

    // R3 data words
    mwrite(5'h18, 16'hA0A1); mwrite(5'h19, 16'hB2B3);
    mwrite(5'h1A, 16'hC4C5); mwrite(5'h1B, 16'hD6D7);
    mread_exp(5'h18, 16'hA0A1, "R3 w0");
    mread_exp(5'h19, 16'hB2B3, "R3 w1");
    mread_exp(5'h1A, 16'hC4C5, "R3 w2");
    mread_exp(5'h1B, 16'hD6D7, "R3 w3");

    // R10 undefined writes touch nothing
    mwrite(5'h12, 16'hFFFF); mwrite(5'h1F, 16'hFFFF); mwrite(5'h00, 16'hFFFF);
    mread_exp(5'h10, 16'h3401, "R10 page kept");
    mread_exp(5'h11, 16'h0000, "R10 cmd kept");
    mread_exp(5'h18, 16'hA0A1, "R10 data kept");
    mread_exp(5'h12, 16'h0000, "R10 still zero");

    // R11 registered read holds without strobe
    mread_raw(5'h1A, v);
    chk("R11 read value", {48'h0, v}, 64'h0000_0000_0000_C4C5);
    mwrite(5'h1A, 16'h1234);
    chk("R11 rdata held", {48'h0, mgmt_rdata}, 64'h0000_0000_0000_C4C5);
    mwrite(5'h1A, 16'hC4C5);

    // R4/R5 write transaction
    resp_lat = 3;
    base = txn_cnt;
    mwrite(5'h11, 16'h2001);
    chk("R4 req", {63'h0, ib_req}, 64'h1);
    chk("R4 we", {63'h0, ib_we}, 64'h1);
    chk("R4 page", {56'h0, ib_page}, 64'h34);
    chk("R4 offset", {56'h0, ib_offset}, 64'h20);
    chk("R4 wdata", ib_wdata, 64'hD6D7_C4C5_B2B3_A0A1);
    mread_exp(5'h11, 16'h2001, "R5 busy bit");
    poll_done("R5 write completes");
    chk("R4 one txn", 64'(txn_cnt - base), 64'h1);
    chk("R4 stored", mem[16'h3420], 64'hD6D7_C4C5_B2B3_A0A1);
    chk("R5 req low", {63'h0, ib_req}, 64'h0);
    mread_exp(5'h11, 16'h2000, "R5 cleared");
    mread_exp(5'h18, 16'hA0A1, "R6 write keeps data");

    // R6 read transaction
    mem[16'h3440] = 64'h0123_4567_89AB_CDEF;
    mwrite(5'h11, 16'h4002);
    chk("R6 read dir", {63'h0, ib_we}, 64'h0);
    mread_exp(5'h11, 16'h4002, "R5 read busy");
    poll_done("R6 read completes");
    mread_exp(5'h18, 16'hCDEF, "R6 w0");
    mread_exp(5'h19, 16'h89AB, "R6 w1");
    mread_exp(5'h1A, 16'h4567, "R6 w2");
    mread_exp(5'h1B, 16'h0123, "R6 w3");

    // R7 both bits set -> read
    mem[16'h3450] = 64'h5555_6666_7777_8888;
    mwrite(5'h11, 16'h5003);
    chk("R7 direction", {63'h0, ib_we}, 64'h0);
    mread_exp(5'h11, 16'h5002, "R7 only read bit");
    poll_done("R7 completes");
    mread_exp(5'h18, 16'h8888, "R7 data");

    // R8 busy ignores command and data writes
    resp_lat = 12;
    base = txn_cnt;
    mwrite(5'h11, 16'h2001);
    mwrite(5'h11, 16'h6002);
    mwrite(5'h18, 16'hBEEF);
    mread_exp(5'h11, 16'h2001, "R8 cmd unchanged");
    mread_exp(5'h18, 16'h8888, "R8 data unchanged");
    poll_done("R8 completes");
    repeat (5) @(negedge clk);
    chk("R8 single txn", 64'(txn_cnt - base), 64'h1);
    chk("R8 wrote held data", mem[16'h3420], 64'h5555_6666_7777_8888);
    chk("R8 no second target", {63'h0, mem.exists(16'h3460)}, 64'h0);
    mread_exp(5'h11, 16'h2000, "R8 idle after");

    // R9 page disabled
    resp_lat = 0;
    mwrite(5'h10, 16'h3400);
    base = txn_cnt;
    mwrite(5'h11, 16'h7001);
    chk("R9 no req", {63'h0, ib_req}, 64'h0);
    mread_exp(5'h11, 16'h7000, "R9 ops clear");
    repeat (5) @(negedge clk);
    chk("R9 no txn", 64'(txn_cnt - base), 64'h0);

    // R2 page persists over several commands
    mem[16'h3540] = 64'h1111_2222_3333_4444;
    mem[16'h3544] = 64'h9999_AAAA_BBBB_CCCC;
    mwrite(5'h10, 16'h3501);
    mwrite(5'h11, 16'h4002);
    chk("R2 page used", {56'h0, ib_page}, 64'h35);
    poll_done("R2 first");
    mwrite(5'h11, 16'h4402);
    chk("R2 page kept", {56'h0, ib_page}, 64'h35);
    poll_done("R2 second");
    mread_exp(5'h18, 16'hCCCC, "R2 second data");
    mread_exp(5'h1B, 16'h9999, "R2 second data hi");
    mread_exp(5'h10, 16'h3501, "R2 page readback after");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule